// File: doc/BRIEF.md
# DMA Peripheral Handshake Controller

This block runs the peripheral side of a DMA handshake for one FIFO port. A peripheral raises a request. The controller waits a programmed number of internal clocks and then raises an acknowledge. After that it drives a read or write strobe toward the peripheral for a programmed width. On the last internal clock of the strobe it pops one word from the outbound FIFO or pushes one word into the inbound FIFO. The controller then holds the acknowledge until the peripheral drops its request.

The internal clock is an enable derived from a slow external timing clock. It ticks on every rising edge of that clock, or on every second rising edge. One 8-bit control input sets the polarities, the timing, the strobe format and the interface mode. A separate load strobe sets the transfer direction.

The FIFO side uses valid/ready rules. For reads, `src_valid_i` means the outbound FIFO holds a word, and `src_ready_o` is a one-cycle pop. For writes, `snk_ready_i` means the inbound FIFO has room, and `snk_valid_o` is a one-cycle push. The controller never starts a transfer against a FIFO that cannot take part in it.

Top module: `dma_hs_ctrl`

## Requirements
- R1: After reset the controller is idle. It issues no pop or push, both strobe lines are high, and the transfer direction is write (direction bit 0).
- R2: The acknowledge asserts on the (2 + `cfg_i[4:3]`)-th internal clock after the internal clock that first samples an active request.
- R3: The strobe asserts together with the acknowledge. It lasts one internal clock when `cfg_i[5]`=0 and two when `cfg_i[5]`=1.
- R4: Each transfer issues exactly one pop (read, direction bit 1) or one push (write, direction bit 0). The pop or push is a single system-clock pulse that follows the strobe's final internal clock. A pop and a push never occur together.
- R5: The request is active high when `cfg_i[1]`=1 and active low when it is 0. The acknowledge is active high when `cfg_i[2]`=1 and active low when it is 0.
- R6: When `cfg_i[6]`=1, the internal clock ticks on every second rising edge of `ext_clk_i`, starting with the second edge after the bit is set. When `cfg_i[6]`=0, it ticks on every rising edge.
- R7: With `cfg_i[0]`=0 (separate strobes), `ctl0_o` is an active-low read strobe and `ctl1_o` is an active-low write strobe. With `cfg_i[0]`=1 (data strobe format), `ctl0_o` is an active-low data strobe and `ctl1_o` is the read/write line, where 1 means read.
- R8: When `cfg_i[7]`=0 (processor mode), requests are ignored. The acknowledge stays inactive, both control lines stay high, `ctl_oe_o` is 0, and no pop or push occurs. When `cfg_i[7]`=1, `ctl_oe_o` is 1.
- R9: A request is not accepted while the FIFO for the current direction blocks: `src_valid_i`=0 for reads, or `snk_ready_i`=0 for writes. The request stays pending and is accepted on the first internal clock after the block clears.
- R10: After the strobe, the acknowledge stays asserted and no new transfer starts until an internal clock samples the request inactive.
- R11: A pulse on `dir_load_i` loads `dir_read_i` as the direction. A transfer uses the direction in force when it was accepted, even if the direction is reloaded during that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_i | input | 1 | External timing clock, sampled as a level |
| cfg_i | input | 8 | Control: [0] strobe format, [1] request polarity, [2] acknowledge polarity, [4:3] delay code, [5] strobe width, [6] divide by two, [7] peripheral mode |
| dir_load_i | input | 1 | Load pulse for the transfer direction |
| dir_read_i | input | 1 | Direction value: 1 read (pop), 0 write (push) |
| req_i | input | 1 | Peripheral request |
| ack_o | output | 1 | Peripheral acknowledge |
| ctl0_o | output | 1 | Read strobe, or data strobe |
| ctl1_o | output | 1 | Write strobe, or read/write line |
| ctl_oe_o | output | 1 | Control line output enable |
| src_valid_i | input | 1 | Outbound FIFO holds data |
| src_ready_o | output | 1 | Pop pulse to outbound FIFO |
| snk_valid_o | output | 1 | Push pulse to inbound FIFO |
| snk_ready_i | input | 1 | Inbound FIFO has room |

## Verification
Two situations are hard to reach from the ports. One is a direction reload while a transfer is already in flight. The other is a request that becomes acceptable only after FIFO back-pressure lifts, some internal clocks after it was raised. The bench drives the external timing clock one rising edge at a time, so every internal clock is a discrete step. It then changes the direction or the FIFO status between two chosen steps and checks the acknowledge, the strobe lines and the pop/push counts after each step.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;
  localparam int CFG_W    = 8;
  localparam int DLY_BASE = 2;
  localparam int DLY_W    = 2;
  localparam int CNT_W    = $clog2(DLY_BASE + (1 << DLY_W));

  typedef struct packed {
    logic             periph;
    logic             div2;
    logic             wide;
    logic [DLY_W-1:0] dly;
    logic             ack_hi;
    logic             req_hi;
    logic             moto;
  } hs_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_STRB = 2'd2,
    ST_DONE = 2'd3
  } hs_state_t;
endpackage

// File: rtl/dma_hs_sync.sv
module dma_hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr[STAGES-1];
endmodule

// File: rtl/dma_hs_tick.sv
module dma_hs_tick #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk_i,
  input  logic div2_i,
  output logic tick_o
);
  logic ext_s;
  logic ext_prev;
  logic phase;
  logic rise;

  dma_hs_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (ext_clk_i),
    .q_o   (ext_s)
  );

  assign rise = ext_s & ~ext_prev;

  // phase is held at zero while undivided, so division always skips the first edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_prev <= 1'b0;
      phase    <= 1'b0;
    end else begin
      ext_prev <= ext_s;
      if (!div2_i)   phase <= 1'b0;
      else if (rise) phase <= ~phase;
    end
  end

  assign tick_o = rise & (~div2_i | phase);
endmodule

// File: rtl/dma_hs_fsm.sv
module dma_hs_fsm
  import dma_hs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick_i,
  input  hs_cfg_t   cfg_i,
  input  logic      req_act_i,
  input  logic      dir_read_i,
  input  logic      src_valid_i,
  input  logic      snk_ready_i,
  output hs_state_t state_o,
  output logic      ack_o,
  output logic      strobe_o,
  output logic      xfer_read_o,
  output logic      pop_o,
  output logic      push_o
);
  hs_state_t        st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] target;
  logic             scnt;
  logic             last_beat;
  logic             fifo_ok;

  assign fifo_ok   = dir_read_i ? src_valid_i : snk_ready_i;
  assign target    = CNT_W'(DLY_BASE) + CNT_W'(cfg_i.dly);
  assign last_beat = cfg_i.wide ? scnt : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      cnt         <= '0;
      scnt        <= 1'b0;
      xfer_read_o <= 1'b0;
      pop_o       <= 1'b0;
      push_o      <= 1'b0;
    end else begin
      pop_o  <= 1'b0;
      push_o <= 1'b0;
      if (!cfg_i.periph) begin
        st   <= ST_IDLE;
        cnt  <= '0;
        scnt <= 1'b0;
      end else if (tick_i) begin
        case (st)
          ST_IDLE: begin
            if (req_act_i && fifo_ok) begin
              st          <= ST_WAIT;
              cnt         <= CNT_W'(1);
              xfer_read_o <= dir_read_i;
            end
          end
          ST_WAIT: begin
            if (cnt == target) begin
              st   <= ST_STRB;
              scnt <= 1'b0;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          ST_STRB: begin
            if (last_beat) begin
              st     <= ST_DONE;
              pop_o  <= xfer_read_o;
              push_o <= ~xfer_read_o;
            end else begin
              scnt <= 1'b1;
            end
          end
          default: begin
            if (!req_act_i) st <= ST_IDLE;
          end
        endcase
      end
    end
  end

  assign state_o  = st;
  assign ack_o    = (st == ST_STRB) || (st == ST_DONE);
  assign strobe_o = (st == ST_STRB);

  AST_ONE_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop_o && push_o)) else $error("pop and push together"); // R4
  AST_MOVE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_o || push_o) |-> $past(tick_i)) else $error("move without tick"); // R4
  AST_START_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && $past(st) == ST_IDLE) |-> $past(fifo_ok && req_act_i))
    else $error("start against blocked fifo"); // R9
  AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DONE && req_act_i && cfg_i.periph) |=> (st == ST_DONE))
    else $error("done left with request active"); // R10
  AST_PROC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_i.periph |=> (st == ST_IDLE && !pop_o && !push_o))
    else $error("activity in processor mode"); // R8
endmodule

// File: rtl/dma_hs_pins.sv
module dma_hs_pins
  import dma_hs_pkg::*;
(
  input  hs_cfg_t cfg_i,
  input  logic    ack_i,
  input  logic    strobe_i,
  input  logic    busy_i,
  input  logic    xfer_read_i,
  input  logic    dir_read_i,
  output logic    ack_o,
  output logic    ctl0_o,
  output logic    ctl1_o,
  output logic    oe_o
);
  logic rw;
  logic ack_act;

  assign rw      = busy_i ? xfer_read_i : dir_read_i;
  assign ack_act = ack_i & cfg_i.periph;
  assign ack_o   = cfg_i.ack_hi ? ack_act : ~ack_act;
  assign oe_o    = cfg_i.periph;

  always_comb begin
    if (!cfg_i.periph) begin
      ctl0_o = 1'b1;
      ctl1_o = 1'b1;
    end else if (cfg_i.moto) begin
      ctl0_o = ~strobe_i;
      ctl1_o = rw;
    end else begin
      ctl0_o = ~(strobe_i & xfer_read_i);
      ctl1_o = ~(strobe_i & ~xfer_read_i);
    end
  end
endmodule

// File: rtl/dma_hs_ctrl.sv
module dma_hs_ctrl
  import dma_hs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_clk_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             dir_load_i,
  input  logic             dir_read_i,
  input  logic             req_i,
  output logic             ack_o,
  output logic             ctl0_o,
  output logic             ctl1_o,
  output logic             ctl_oe_o,
  input  logic             src_valid_i,
  output logic             src_ready_o,
  output logic             snk_valid_o,
  input  logic             snk_ready_i
);
  hs_cfg_t   cfg;
  hs_state_t st;
  logic      tick;
  logic      req_s;
  logic      req_act;
  logic      dir_read_q;
  logic      ack_int;
  logic      strobe;
  logic      xfer_read;

  assign cfg = hs_cfg_t'(cfg_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          dir_read_q <= 1'b0;
    else if (dir_load_i) dir_read_q <= dir_read_i;
  end

  dma_hs_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (req_i),
    .q_o   (req_s)
  );

  assign req_act = cfg.req_hi ? req_s : ~req_s;

  dma_hs_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_clk_i (ext_clk_i),
    .div2_i    (cfg.div2),
    .tick_o    (tick)
  );

  dma_hs_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .cfg_i       (cfg),
    .req_act_i   (req_act),
    .dir_read_i  (dir_read_q),
    .src_valid_i (src_valid_i),
    .snk_ready_i (snk_ready_i),
    .state_o     (st),
    .ack_o       (ack_int),
    .strobe_o    (strobe),
    .xfer_read_o (xfer_read),
    .pop_o       (src_ready_o),
    .push_o      (snk_valid_o)
  );

  dma_hs_pins u_pins (
    .cfg_i       (cfg),
    .ack_i       (ack_int),
    .strobe_i    (strobe),
    .busy_i      (st != ST_IDLE),
    .xfer_read_i (xfer_read),
    .dir_read_i  (dir_read_q),
    .ack_o       (ack_o),
    .ctl0_o      (ctl0_o),
    .ctl1_o      (ctl1_o),
    .oe_o        (ctl_oe_o)
  );

  AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |-> ($past(st) == ST_WAIT)) else $error("strobe without delay"); // R3
endmodule

// File: tb/tb_dma_hs_ctrl.sv
module tb_dma_hs_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_clk = 1'b0;
  logic [7:0] cfg = 8'h00;
  logic       dir_load = 1'b0;
  logic       dir_read = 1'b0;
  logic       req = 1'b0;
  logic       src_valid = 1'b1;
  logic       snk_ready = 1'b1;
  logic       ack, ctl0, ctl1, ctl_oe, src_ready, snk_valid;

  int checks = 0;
  int errors = 0;
  int pop_cnt = 0;
  int push_cnt = 0;

  always #10 clk = ~clk;

  dma_hs_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk), .cfg_i(cfg),
    .dir_load_i(dir_load), .dir_read_i(dir_read), .req_i(req),
    .ack_o(ack), .ctl0_o(ctl0), .ctl1_o(ctl1), .ctl_oe_o(ctl_oe),
    .src_valid_i(src_valid), .src_ready_o(src_ready),
    .snk_valid_o(snk_valid), .snk_ready_i(snk_ready)
  );

  always @(negedge clk) begin
    if (src_ready) pop_cnt++;
    if (snk_valid) push_cnt++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic ack_pin(input logic active);
    return cfg[2] ? active : ~active;
  endfunction

  function automatic logic [1:0] ctl_exp(input logic stb, input logic rd);
    if (!cfg[7])     return 2'b11;
    else if (cfg[0]) return {~stb, rd};
    else             return {~(stb & rd), ~(stb & ~rd)};
  endfunction

  task automatic set_cfg(input logic [7:0] c);
    @(negedge clk);
    cfg = c;
    req = c[1] ? 1'b0 : 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic drive_req(input logic a);
    @(negedge clk);
    req = cfg[1] ? a : ~a;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_dir(input logic rd);
    @(negedge clk);
    dir_load = 1'b1;
    dir_read = rd;
    @(negedge clk);
    dir_load = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk);
    ext_clk = 1'b1;
    repeat (2) @(negedge clk);
    ext_clk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // full transfer, checked after every internal clock
  task automatic run_xfer(input logic [7:0] c, input logic rd, input logic load_dir);
    int n, w, p0, q0;
    logic [1:0] ce;
    set_cfg(c);
    if (load_dir) set_dir(rd);
    src_valid = 1'b1;
    snk_ready = 1'b1;
    n = 2 + int'(c[4:3]);
    w = c[5] ? 2 : 1;
    p0 = pop_cnt;
    q0 = push_cnt;
    drive_req(1'b1);
    for (int k = 1; k <= n + w + 1; k++) begin
      if (c[6]) begin
        pulse();
        chk("R6 ack unchanged on skipped edge", int'(ack), int'(ack_pin(k - 1 >= n + 1)));
      end
      pulse();
      chk("R2/R5 ack timing", int'(ack), int'(ack_pin(k >= n + 1)));
      ce = ctl_exp((k >= n + 1) && (k <= n + w), rd);
      chk("R3/R7 ctl0", int'(ctl0), int'(ce[1]));
      chk("R3/R7 ctl1", int'(ctl1), int'(ce[0]));
      chk("R4 pops", pop_cnt - p0, (rd && k == n + w + 1) ? 1 : 0);
      chk("R4 pushes", push_cnt - q0, (!rd && k == n + w + 1) ? 1 : 0);
    end
    drive_req(1'b0);
    pulse();
    if (c[6]) pulse();
    chk("R10 ack released", int'(ack), int'(ack_pin(1'b0)));
    chk("R4 single move", (pop_cnt - p0) + (push_cnt - q0), 1);
  endtask

  task automatic test_reset();
    chk("R1 ack idle", int'(ack), 1);
    chk("R1 ctl0 high", int'(ctl0), 1);
    chk("R1 ctl1 high", int'(ctl1), 1);
    chk("R1 no moves", pop_cnt + push_cnt, 0);
    // direction defaults to write: first transfer without loading must push
    run_xfer(8'h86, 1'b0, 1'b0);
    chk("R1 default write", push_cnt, 1);
  endtask

  task automatic test_backpressure();
    int p0, q0;
    set_cfg(8'h86);
    set_dir(1'b1);
    src_valid = 1'b0;
    p0 = pop_cnt;
    drive_req(1'b1);
    for (int k = 0; k < 3; k++) begin
      pulse();
      chk("R9 blocked read ack", int'(ack), 0);
    end
    chk("R9 no pop while empty", pop_cnt - p0, 0);
    @(negedge clk) src_valid = 1'b1;
    pulse(); pulse();
    chk("R9 pending ack not yet", int'(ack), 0);
    pulse();
    chk("R9 pending accepted", int'(ack), 1);
    pulse();
    chk("R9 pop after release", pop_cnt - p0, 1);
    drive_req(1'b0); pulse();
    set_dir(1'b0);
    snk_ready = 1'b0;
    q0 = push_cnt;
    drive_req(1'b1);
    pulse(); pulse();
    chk("R9 blocked write ack", int'(ack), 0);
    @(negedge clk) snk_ready = 1'b1;
    pulse(); pulse(); pulse();
    chk("R9 write accepted", int'(ack), 1);
    pulse();
    chk("R9 push after room", push_cnt - q0, 1);
    drive_req(1'b0); pulse();
  endtask

  task automatic test_done_hold();
    int p0;
    set_cfg(8'h86);
    set_dir(1'b1);
    p0 = pop_cnt;
    drive_req(1'b1);
    repeat (4) pulse();
    repeat (3) pulse();
    chk("R10 ack held", int'(ack), 1);
    chk("R10 no second pop", pop_cnt - p0, 1);
    drive_req(1'b0);
    pulse();
    chk("R10 ack drops", int'(ack), 0);
    drive_req(1'b1);
    repeat (4) pulse();
    chk("R10 next transfer", pop_cnt - p0, 2);
    drive_req(1'b0); pulse();
  endtask

  task automatic test_dir_midflight();
    int p0, q0;
    set_cfg(8'h86);
    set_dir(1'b1);
    p0 = pop_cnt;
    q0 = push_cnt;
    drive_req(1'b1);
    pulse();
    set_dir(1'b0);
    pulse(); pulse();
    chk("R11 read strobe kept", int'(ctl0), 0);
    chk("R11 write strobe idle", int'(ctl1), 1);
    pulse();
    chk("R11 popped", pop_cnt - p0, 1);
    chk("R11 not pushed", push_cnt - q0, 0);
    drive_req(1'b0); pulse();
    drive_req(1'b1);
    repeat (4) pulse();
    chk("R11 new dir used", push_cnt - q0, 1);
    drive_req(1'b0); pulse();
  endtask

  task automatic test_processor();
    int m0;
    set_cfg(8'h06);
    m0 = pop_cnt + push_cnt;
    drive_req(1'b1);
    repeat (6) pulse();
    chk("R8 ack inactive", int'(ack), 0);
    chk("R8 ctl0 high", int'(ctl0), 1);
    chk("R8 ctl1 high", int'(ctl1), 1);
    chk("R8 oe low", int'(ctl_oe), 0);
    chk("R8 no moves", pop_cnt + push_cnt - m0, 0);
    drive_req(1'b0);
    set_cfg(8'h86);
    chk("R8 oe high in peripheral", int'(ctl_oe), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    run_xfer(8'h86, 1'b1, 1'b1);
    run_xfer(8'hBE, 1'b0, 1'b1);
    run_xfer(8'hC9, 1'b1, 1'b1);
    run_xfer(8'hB3, 1'b0, 1'b1);
    test_backpressure();
    test_done_hold();
    test_dir_midflight();
    test_processor();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule